// File: doc/BRIEF.md
# Debiased Entropy Collector with Health Tests

This block turns a raw one-bit noise stream into a 192-bit entropy holding buffer. While the source enable is high it takes one raw sample every programmable number of clock cycles. Each sample either goes straight into the buffer or first passes through a pair-wise Von Neumann debiaser. Two online health tests watch the collected stream. One reports a long run of identical bits. The other reports a 16-bit block that repeats the block before it.

Once the buffer is full, a valid flag rises, collection stops and the contents stay frozen. Software reads the buffer as six 32-bit words through a word select. To start a fresh collection, software drops the source enable and pulses the bits-counter clear.

Top module: `entropy_collector`

## Requirements
- R1: While `src_en` is high and `valid` is low, the block takes one raw sample every P clock cycles, where P is `sample_period`. A value of 0 behaves as 1. The first sample is taken on the P-th rising edge after `src_en` rises.
- R2: With the debiaser active (`vn_bypass`=0), samples are grouped into non-overlapping pairs, counted from the first sample after a clear. The pair (first=0, second=1) yields collected bit 0. The pair (1, 0) yields 1. The pairs (0, 0) and (1, 1) yield nothing.
- R3: With `vn_bypass`=1, every sample becomes a collected bit. In this mode `sample_period` must be at least 17 while `src_en` is high.
- R4: With the debiaser active, `vn_err` pulses for one cycle when 32 consecutive collected bits are identical. Counting then restarts, so a stream of 192 equal bits gives 6 pulses. With `vn_bypass`=1, `vn_err` stays low.
- R5: Collected bits form 16-bit blocks, aligned to the first bit after a clear. `rep_err` pulses for one cycle when a block equals the block just before it. With `rep_bypass`=1, `rep_err` stays low.
- R6: The k-th collected bit (k from 0) is stored at buffer bit k. With `rd_sel`=w for w in 0..5, `rd_word` returns buffer bits 32w+31..32w. Select values 6 and 7 return 0.
- R7: `valid` rises after 192 bits have been collected. From then until a clear, no further bits are collected and the buffer does not change, even while `src_en` stays high.
- R8: `cnt_clear` takes effect only while `src_en` is low. It zeroes the bit count, drops `valid`, restarts the debias pairing and restarts both health tests. While `src_en` is high it has no effect.
- R9: `busy` is high exactly when `src_en` is high and `valid` is low.
- R10: After reset, `valid`, `busy`, `vn_err` and `rep_err` are low and every buffer word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 1 | Source enable; sampling runs only while high |
| sample_period | input | 32 | Clock cycles between two raw samples |
| raw_bit | input | 1 | Raw entropy sample input |
| vn_bypass | input | 1 | Skip the debiaser and the run test |
| rep_bypass | input | 1 | Disable the block repetition test |
| cnt_clear | input | 1 | Clear bit count and valid (only while disabled) |
| rd_sel | input | 3 | Buffer word select |
| rd_word | output | 32 | Selected buffer word |
| vn_err | output | 1 | Run-of-identical-bits error pulse |
| rep_err | output | 1 | Repeated-block error pulse |
| valid | output | 1 | Buffer full |
| busy | output | 1 | Collection in progress |

## Verification
The assertions take three things for granted about the inputs. First, in bypass mode the sample period is at least 17 while the source is enabled. Second, the clear only matters while the source is low. Third, the bypass controls and the period are changed only while the source is disabled. The stimulus keeps to all three: before every run the bench drops the enable, sets the controls and period, and pulses the clear, and it uses a period of 17 for every bypass run. The bench changes the raw input only at a falling edge, one sample window at a time. It derives the expected buffer and the expected error pulse counts from the sample sequence it drove.

// File: rtl/ec_pkg.sv
package ec_pkg;
   // one collected or sampled bit with its strobe
   typedef struct packed {
      logic vld;
      logic val;
   } ec_bit_t;
endpackage

// File: rtl/ec_sampler.sv
module ec_sampler #(
   parameter int PER_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   input  logic             raw_bit,
   output ec_pkg::ec_bit_t  smp
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] lim;
   logic             hit;

   assign lim = (period == '0) ? '0 : period - 1'b1;
   assign hit = run && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || hit)  cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   assign smp.vld = hit;
   assign smp.val = raw_bit;

   // after a strobe the interval restarts, so a back-to-back strobe needs P=1
   p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
      smp.vld |=> (!smp.vld || lim == '0));
endmodule

// File: rtl/ec_debias.sv
module ec_debias (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            bypass,
   input  ec_pkg::ec_bit_t smp,
   output ec_pkg::ec_bit_t col
);
   logic            phase_q;
   logic            first_q;
   ec_pkg::ec_bit_t col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         first_q <= 1'b0;
         col_q   <= '0;
      end else begin
         col_q.vld <= 1'b0;
         if (clr) begin
            phase_q <= 1'b0;
         end else if (smp.vld) begin
            if (bypass) begin
               col_q <= '{vld: 1'b1, val: smp.val};
            end else if (!phase_q) begin
               first_q <= smp.val;
               phase_q <= 1'b1;
            end else begin
               phase_q <= 1'b0;
               if (first_q != smp.val) col_q <= '{vld: 1'b1, val: first_q};
            end
         end
      end
   end

   assign col = col_q;

   // a clear happens only with sampling stopped, so nothing leaves next cycle
   p_clr_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !col.vld);
endmodule

// File: rtl/ec_health.sv
module ec_health #(
   parameter int RUN_LEN = 32,
   parameter int BLK_W   = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic acc,
   input  logic val,
   input  logic vn_bypass,
   input  logic rep_bypass,
   output logic vn_err,
   output logic rep_err
);
   localparam int RUN_W  = $clog2(RUN_LEN + 1);
   localparam int BCNT_W = $clog2(BLK_W);

   logic [RUN_W-1:0]  run_q, run_nx;
   logic              last_q;
   logic [BLK_W-1:0]  blk_q, blk_nx, prev_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic              have_prev_q;

   assign run_nx = (run_q != '0 && val == last_q) ? run_q + 1'b1 : RUN_W'(1);
   assign blk_nx = {blk_q[BLK_W-2:0], val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0; last_q <= 1'b0; blk_q <= '0; prev_q <= '0;
         bcnt_q <= '0; have_prev_q <= 1'b0; vn_err <= 1'b0; rep_err <= 1'b0;
      end else begin
         vn_err  <= 1'b0;
         rep_err <= 1'b0;
         if (clr) begin
            run_q <= '0; bcnt_q <= '0; have_prev_q <= 1'b0;
         end else if (acc) begin
            last_q <= val;
            if (run_nx == RUN_W'(RUN_LEN)) begin
               vn_err <= !vn_bypass;
               run_q  <= '0;
            end else begin
               run_q <= run_nx;
            end
            if (bcnt_q == BCNT_W'(BLK_W - 1)) begin
               rep_err     <= !rep_bypass && have_prev_q && (blk_nx == prev_q);
               prev_q      <= blk_nx;
               have_prev_q <= 1'b1;
               bcnt_q      <= '0;
            end else begin
               bcnt_q <= bcnt_q + 1'b1;
            end
            blk_q <= blk_nx;
         end
      end
   end

   p_run_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vn_bypass |=> !vn_err);
   p_rep_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rep_bypass |=> !rep_err);
   p_err_needs_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> (!vn_err && !rep_err));
endmodule

// File: rtl/ec_holding.sv
module ec_holding #(
   parameter int DEPTH  = 192,
   parameter int WORD_W = 32,
   localparam int NWORDS = DEPTH / WORD_W,
   localparam int SEL_W  = $clog2(NWORDS + 1),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  ec_pkg::ec_bit_t   col,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic              acc,
   output logic              valid,
   output logic [WORD_W-1:0] rd_word
);
   logic [DEPTH-1:0]  store_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] words [NWORDS];

   assign acc = col.vld && !valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         cnt_q   <= '0;
         valid   <= 1'b0;
      end else if (clr) begin
         cnt_q <= '0;
         valid <= 1'b0;
      end else if (acc) begin
         store_q[cnt_q] <= col.val;
         cnt_q          <= cnt_q + 1'b1;
         if (cnt_q == CNT_W'(DEPTH - 1)) valid <= 1'b1;
      end
   end

   for (genvar g = 0; g < NWORDS; g++) begin : g_word
      assign words[g] = store_q[g*WORD_W +: WORD_W];
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NWORDS; i++)
         if (int'(rd_sel) == i) rd_word = words[i];
   end

   p_valid_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr) |=> valid);
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clr) |=> $stable(store_q));
   p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector #(
   parameter int DEPTH          = 192,
   parameter int WORD_W         = 32,
   parameter int PER_W          = 32,
   parameter int RUN_LEN        = 32,
   parameter int BLK_W          = 16,
   parameter int MIN_BYP_PERIOD = 17,
   localparam int NWORDS = DEPTH / WORD_W,
   localparam int SEL_W  = $clog2(NWORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_en,
   input  logic [PER_W-1:0]  sample_period,
   input  logic              raw_bit,
   input  logic              vn_bypass,
   input  logic              rep_bypass,
   input  logic              cnt_clear,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word,
   output logic              vn_err,
   output logic              rep_err,
   output logic              valid,
   output logic              busy
);
   if (DEPTH % WORD_W != 0) begin : g_bad_depth
      $error("DEPTH must be a whole number of words");
   end
   if (DEPTH % BLK_W != 0 || BLK_W < 2) begin : g_bad_blk
      $error("BLK_W must be at least 2 and divide DEPTH");
   end
   if (RUN_LEN < 2) begin : g_bad_run
      $error("RUN_LEN must be at least 2");
   end

   ec_pkg::ec_bit_t smp, col;
   logic clr_ok, acc;

   assign clr_ok = cnt_clear && !src_en;
   assign busy   = src_en && !valid;

   ec_sampler #(.PER_W(PER_W)) u_smp (
      .clk(clk), .rst_n(rst_n), .run(src_en && !valid),
      .period(sample_period), .raw_bit(raw_bit), .smp(smp));

   ec_debias u_vn (
      .clk(clk), .rst_n(rst_n), .clr(clr_ok), .bypass(vn_bypass),
      .smp(smp), .col(col));

   ec_holding #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(clr_ok), .col(col), .rd_sel(rd_sel),
      .acc(acc), .valid(valid), .rd_word(rd_word));

   ec_health #(.RUN_LEN(RUN_LEN), .BLK_W(BLK_W)) u_hlth (
      .clk(clk), .rst_n(rst_n), .clr(clr_ok), .acc(acc), .val(col.val),
      .vn_bypass(vn_bypass), .rep_bypass(rep_bypass),
      .vn_err(vn_err), .rep_err(rep_err));

   // input constraint on the bypass path
   p_min_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en && vn_bypass) |-> (sample_period >= PER_W'(MIN_BYP_PERIOD)));
endmodule

// File: tb/tb_entropy_collector.sv
module tb_entropy_collector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_en = 1'b0;
   logic [31:0] sample_period = 32'd17;
   logic        raw_bit = 1'b0;
   logic        vn_bypass = 1'b0;
   logic        rep_bypass = 1'b0;
   logic        cnt_clear = 1'b0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_word;
   logic        vn_err, rep_err, valid, busy;

   always #2 clk = ~clk;

   entropy_collector dut (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .sample_period(sample_period),
      .raw_bit(raw_bit), .vn_bypass(vn_bypass), .rep_bypass(rep_bypass),
      .cnt_clear(cnt_clear), .rd_sel(rd_sel), .rd_word(rd_word),
      .vn_err(vn_err), .rep_err(rep_err), .valid(valid), .busy(busy));

   int checks = 0, errors = 0, n_vn = 0, n_rep = 0;
   bit done = 0;
   bit exp_bits [192];
   int ncol = 0;
   bit have_first = 0, first_s = 0;
   bit cur_vb = 0, cur_rb = 0;
   int unsigned x = 32'h1234_5679;

   always @(negedge clk) begin
      if (vn_err === 1'b1)  n_vn++;
      if (rep_err === 1'b1) n_rep++;
   end

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit next_sample(int kind, int j);
      case (kind)
         0: begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            return x[0];
         end
         1: return (j % 2 == 0);
         2: return 16'hA5C3 >> (j % 16);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_word(int w);
      logic [31:0] e;
      for (int b = 0; b < 32; b++) e[b] = exp_bits[32*w + b];
      return e;
   endfunction

   function automatic int exp_runs();
      int run = 0, cnt = 0, nl;
      bit last = 0;
      if (cur_vb) return 0;
      for (int k = 0; k < 192; k++) begin
         nl = (run != 0 && exp_bits[k] == last) ? run + 1 : 1;
         last = exp_bits[k];
         if (nl == 32) begin cnt++; run = 0; end else run = nl;
      end
      return cnt;
   endfunction

   function automatic int exp_reps();
      int cnt = 0;
      bit same;
      if (cur_rb) return 0;
      for (int i = 1; i < 12; i++) begin
         same = 1;
         for (int b = 0; b < 16; b++)
            if (exp_bits[16*i + b] != exp_bits[16*(i-1) + b]) same = 0;
         if (same) cnt++;
      end
      return cnt;
   endfunction

   task automatic prepare(int period, bit vb, bit rb);
      @(negedge clk);
      src_en = 0;
      sample_period = period;
      vn_bypass = vb; rep_bypass = rb;
      cur_vb = vb; cur_rb = rb;
      cnt_clear = 1;
      @(negedge clk);
      cnt_clear = 0;
      n_vn = 0; n_rep = 0;
      ncol = 0; have_first = 0;
   endtask

   task automatic collect(int kind, int target, int period);
      int j = 0;
      bit s;
      int waits = (period == 0) ? 1 : period;
      src_en = 1;
      while (ncol < target && j < 6000) begin
         s = next_sample(kind, j);
         raw_bit = s;
         repeat (waits) @(negedge clk);
         if (cur_vb) begin
            exp_bits[ncol] = s; ncol++;
         end else if (!have_first) begin
            first_s = s; have_first = 1;
         end else begin
            have_first = 0;
            if (first_s != s) begin exp_bits[ncol] = first_s; ncol++; end
         end
         j++;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic check_words(string req);
      for (int w = 0; w < 6; w++) begin
         rd_sel = 3'(w);
         #1;
         chk(req, $sformatf("word%0d", w), rd_word, exp_word(w));
      end
      @(negedge clk);
   endtask

   task automatic full_check(string req);
      chk("R7", "valid after 192 bits", {31'b0, valid}, 32'd1);
      chk("R9", "busy when full", {31'b0, busy}, 32'd0);
      check_words(req);
      chk("R4", "run error pulses", n_vn, exp_runs());
      chk("R5", "repeat error pulses", n_rep, exp_reps());
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10: reset state
      chk("R10", "valid", {31'b0, valid}, 32'd0);
      chk("R10", "busy", {31'b0, busy}, 32'd0);
      chk("R10", "errors", {30'b0, vn_err, rep_err}, 32'd0);
      for (int w = 0; w < 6; w++) begin
         rd_sel = 3'(w); #1;
         chk("R10", "word after reset", rd_word, 32'd0);
      end
      @(negedge clk);

      // R3 / R6: bypassed debiaser, random samples
      prepare(17, 1, 0);
      collect(0, 192, 17);
      full_check("R3");

      // R2: debiased random samples
      prepare(2, 0, 0);
      collect(0, 192, 2);
      full_check("R2");

      // R4: alternating raw gives all-ones collected; repetition test bypassed
      prepare(2, 0, 1);
      collect(1, 192, 2);
      full_check("R4");
      chk("R4", "six run pulses", n_vn, 32'd6);

      // R5: repeating 16-bit pattern in bypass mode
      prepare(17, 1, 0);
      collect(2, 192, 17);
      full_check("R5");
      chk("R5", "eleven repeat pulses", n_rep, 32'd11);

      // R7: buffer frozen while enabled and full
      for (int k = 0; k < 100; k++) begin
         raw_bit = ~raw_bit;
         @(negedge clk);
      end
      chk("R7", "valid held", {31'b0, valid}, 32'd1);
      check_words("R7");
      chk("R7", "no pulses after full", n_vn + n_rep, 32'd11);
      // R8: clear ignored while enabled
      cnt_clear = 1; @(negedge clk); cnt_clear = 0; @(negedge clk);
      chk("R8", "clear ignored when enabled", {31'b0, valid}, 32'd1);
      check_words("R8");
      // R6: out-of-range select
      rd_sel = 3'd6; #1;
      chk("R6", "select 6 reads zero", rd_word, 32'd0);
      rd_sel = 3'd7; #1;
      chk("R6", "select 7 reads zero", rd_word, 32'd0);
      @(negedge clk);
      src_en = 0; @(negedge clk);
      chk("R9", "busy with source off", {31'b0, busy}, 32'd0);
      cnt_clear = 1; @(negedge clk); cnt_clear = 0; @(negedge clk);
      chk("R8", "clear drops valid", {31'b0, valid}, 32'd0);

      // R8: partial collection, clear, then a full fresh run
      prepare(17, 1, 1);
      collect(0, 40, 17);
      chk("R9", "busy while collecting", {31'b0, busy}, 32'd1);
      chk("R7", "not valid at 40 bits", {31'b0, valid}, 32'd0);
      prepare(17, 1, 1);
      collect(0, 192, 17);
      full_check("R8");

      // R1: period 0 behaves as 1, debiaser on
      prepare(0, 0, 0);
      collect(0, 192, 0);
      full_check("R1");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule